// File: doc/BRIEF.md
# Load Data Extension Formatter

This block sits between the memory read or write data path and the register file of a 32-bit core. For loads it takes the raw data returned by memory (one word, or a pair of words for a doubleword), the two low address bits and the access type. It picks the right byte or halfword lane, extends it to 32 bits with zeros or with copies of the sign bit, and produces one or two register write values with their destination indices and write enables. For stores it does the reverse. The low byte or halfword of the source is copied into every lane, and the matching byte enables are produced.

The block also checks each request for encodings that are not allowed. Signed types are illegal for stores. A doubleword must start on an even register that is not the link register. A reserved type code is illegal. An illegal request raises a flag and drives no write enable and no byte enable. The logic is combinational. A parameter can add one register stage on the outputs.

Top module: `ldfmt_top`

## Requirements
- R1: Access type code 0 (unsigned byte) loads byte lane addr_lo[1:0] of mem_data[31:0]. Lane 0 is bits 7:0 and lane 3 is bits 31:24. The byte is zero-extended into wr0_data.
- R2: Access type code 1 (signed byte) loads the same lane as R1 and sign-extends it from bit 7.
- R3: Access type code 2 (unsigned halfword) loads halfword addr_lo[1] of mem_data[31:0] and zero-extends it. Halfword 0 is bits 15:0. addr_lo[0] has no effect.
- R4: Access type code 3 (signed halfword) loads the same halfword as R3 and sign-extends it from bit 15.
- R5: Access type code 4 (word) loads mem_data[31:0] unchanged into wr0_data for any addr_lo. wr1_en stays low.
- R6: Access type code 5 (doubleword) writes mem_data[31:0] to register rd_idx and mem_data[63:32] to register rd_idx+1. Both wr0_en and wr1_en are high.
- R7: A doubleword with an odd rd_idx, or with rd_idx equal to LINK_IDX (14), raises illegal and asserts no enable.
- R8: A store (is_store=1) with type code 1 or 3 raises illegal and asserts no write enable and no byte enable.
- R9: Type codes 6 and 7 are reserved. They raise illegal for loads and for stores, and assert no enable.
- R10: A legal store drives st_data and st_be, and no register write. A byte store replicates store_src[7:0] into all four lanes, with st_be = 1 << addr_lo. A halfword store replicates store_src[15:0], with st_be = 0011 or 1100 chosen by addr_lo[1]. A word store gives st_be = 0x0F. A doubleword store passes store_src[63:0] with st_be = 0xFF. Unused upper data is zero.
- R11: With REG_OUT=1, every output appears one clock after its request, and an active reset clears out_valid, illegal and all enables. With REG_OUT=0, the outputs follow the inputs in the same cycle.
- R12: When req_valid is low, out_valid, illegal, wr0_en, wr1_en and st_be are all zero, as are the data outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| is_store | input | 1 | 1 = store, 0 = load |
| acc_type | input | 3 | 0 UB, 1 SB, 2 UH, 3 SH, 4 word, 5 doubleword, 6/7 reserved |
| addr_lo | input | 2 | Low two bits of the byte address |
| rd_idx | input | RIDX_W | First destination register index |
| mem_data | input | 64 | Read data; bits 31:0 lower-addressed word |
| store_src | input | 64 | Store source data |
| out_valid | output | 1 | Result valid |
| illegal | output | 1 | Illegal encoding flag |
| wr0_en | output | 1 | First register write enable |
| wr0_idx | output | RIDX_W | First register index |
| wr0_data | output | 32 | First register write value |
| wr1_en | output | 1 | Second register write enable |
| wr1_idx | output | RIDX_W | Second register index |
| wr1_data | output | 32 | Second register write value |
| st_data | output | 64 | Formatted store data |
| st_be | output | 8 | Store byte enables |

## Verification
The bench builds the block with REG_OUT=1 and the default 4-bit register index, so the whole register range r0 to r15 can be swept. The sweep crosses all eight type codes, all four address offsets, loads and stores, and every register index. It uses data patterns with the sign bits of each lane set, clear and mixed. This covers every lane and extension choice, every even, odd and link-register doubleword base, and all of the illegal encodings. The registered build also makes the one-cycle latency and the clearing by reset observable at the ports.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned PAIR_W  = 2 * WORD_W;
    localparam int unsigned LANES   = WORD_W / 8;
    localparam int unsigned BE_W    = PAIR_W / 8;

    typedef enum logic [2:0] {
        ACC_UBYTE = 3'd0,
        ACC_SBYTE = 3'd1,
        ACC_UHALF = 3'd2,
        ACC_SHALF = 3'd3,
        ACC_WORD  = 3'd4,
        ACC_DWORD = 3'd5,
        ACC_RSV6  = 3'd6,
        ACC_RSV7  = 3'd7
    } acc_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_PAIR = 2'd3
    } size_e;

endpackage

// File: rtl/ldfmt_decode.sv
module ldfmt_decode
    import ldfmt_pkg::*;
#(
    parameter int unsigned RIDX_W   = 4,
    parameter int unsigned LINK_IDX = 14
) (
    input  logic              req_valid,
    input  logic              is_store,
    input  logic [2:0]        acc_type,
    input  logic [RIDX_W-1:0] rd_idx,
    output size_e             size,
    output logic              sext,
    output logic              bad_enc,
    output logic              load_ok,
    output logic              store_ok,
    output logic              pair_ok
);

    localparam logic [RIDX_W-1:0] LINK_R = RIDX_W'(LINK_IDX);

    acc_e kind;
    logic reserved;
    logic signed_store;
    logic bad_pair;

    assign kind = acc_e'(acc_type);

    always_comb begin
        size     = SZ_WORD;
        sext     = 1'b0;
        reserved = 1'b0;
        unique case (kind)
            ACC_UBYTE: size = SZ_BYTE;
            ACC_SBYTE: begin size = SZ_BYTE; sext = 1'b1; end
            ACC_UHALF: size = SZ_HALF;
            ACC_SHALF: begin size = SZ_HALF; sext = 1'b1; end
            ACC_WORD:  size = SZ_WORD;
            ACC_DWORD: size = SZ_PAIR;
            ACC_RSV6:  reserved = 1'b1;
            ACC_RSV7:  reserved = 1'b1;
        endcase
    end

    assign signed_store = is_store && sext;
    assign bad_pair     = (size == SZ_PAIR) && !reserved &&
                          (rd_idx[0] || (rd_idx == LINK_R));

    assign bad_enc  = req_valid && (reserved || signed_store || bad_pair);
    assign load_ok  = req_valid && !is_store && !bad_enc;
    assign store_ok = req_valid &&  is_store && !bad_enc;
    assign pair_ok  = load_ok && (size == SZ_PAIR);

endmodule

// File: rtl/ldfmt_extract.sv
module ldfmt_extract
    import ldfmt_pkg::*;
(
    input  logic [PAIR_W-1:0] mem_data,
    input  logic [1:0]        addr_lo,
    input  size_e             size,
    input  logic              sext,
    output logic [WORD_W-1:0] val0,
    output logic [WORD_W-1:0] val1
);

    logic [7:0]  lane  [LANES];
    logic [15:0] hlane [LANES/2];
    logic [7:0]  bsel;
    logic [15:0] hsel;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = mem_data[8*g +: 8];
    end

    for (genvar h = 0; h < LANES/2; h++) begin : g_half
        assign hlane[h] = mem_data[16*h +: 16];
    end

    assign bsel = lane[addr_lo];
    assign hsel = hlane[addr_lo[1]];

    always_comb begin
        val1 = '0;
        unique case (size)
            SZ_BYTE: val0 = {{(WORD_W-8){sext & bsel[7]}}, bsel};
            SZ_HALF: val0 = {{(WORD_W-16){sext & hsel[15]}}, hsel};
            SZ_WORD: val0 = mem_data[WORD_W-1:0];
            SZ_PAIR: begin
                val0 = mem_data[WORD_W-1:0];
                val1 = mem_data[PAIR_W-1:WORD_W];
            end
        endcase
    end

endmodule

// File: rtl/ldfmt_store_pack.sv
module ldfmt_store_pack
    import ldfmt_pkg::*;
(
    input  logic [PAIR_W-1:0] store_src,
    input  logic [1:0]        addr_lo,
    input  size_e             size,
    output logic [PAIR_W-1:0] pk_data,
    output logic [BE_W-1:0]   pk_be
);

    logic [WORD_W-1:0] rep_b;
    logic [WORD_W-1:0] rep_h;

    for (genvar g = 0; g < LANES; g++) begin : g_rep_b
        assign rep_b[8*g +: 8] = store_src[7:0];
    end

    for (genvar h = 0; h < LANES/2; h++) begin : g_rep_h
        assign rep_h[16*h +: 16] = store_src[15:0];
    end

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                pk_data = {{WORD_W{1'b0}}, rep_b};
                pk_be   = BE_W'(4'b0001 << addr_lo);
            end
            SZ_HALF: begin
                pk_data = {{WORD_W{1'b0}}, rep_h};
                pk_be   = addr_lo[1] ? BE_W'(4'b1100) : BE_W'(4'b0011);
            end
            SZ_WORD: begin
                pk_data = {{WORD_W{1'b0}}, store_src[WORD_W-1:0]};
                pk_be   = BE_W'(4'b1111);
            end
            SZ_PAIR: begin
                pk_data = store_src;
                pk_be   = '1;
            end
        endcase
    end

endmodule

// File: rtl/ldfmt_top.sv
module ldfmt_top
    import ldfmt_pkg::*;
#(
    parameter int unsigned RIDX_W   = 4,
    parameter int unsigned LINK_IDX = 14,
    parameter bit          REG_OUT  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              is_store,
    input  logic [2:0]        acc_type,
    input  logic [1:0]        addr_lo,
    input  logic [RIDX_W-1:0] rd_idx,
    input  logic [63:0]       mem_data,
    input  logic [63:0]       store_src,
    output logic              out_valid,
    output logic              illegal,
    output logic              wr0_en,
    output logic [RIDX_W-1:0] wr0_idx,
    output logic [31:0]       wr0_data,
    output logic              wr1_en,
    output logic [RIDX_W-1:0] wr1_idx,
    output logic [31:0]       wr1_data,
    output logic [63:0]       st_data,
    output logic [7:0]        st_be
);

    typedef struct packed {
        logic              vld;
        logic              bad;
        logic              w0_en;
        logic [RIDX_W-1:0] w0_idx;
        logic [WORD_W-1:0] w0_dat;
        logic              w1_en;
        logic [RIDX_W-1:0] w1_idx;
        logic [WORD_W-1:0] w1_dat;
        logic [PAIR_W-1:0] s_dat;
        logic [BE_W-1:0]   s_be;
    } res_t;

    size_e             size;
    logic              sext;
    logic              bad_enc;
    logic              load_ok;
    logic              store_ok;
    logic              pair_ok;
    logic [WORD_W-1:0] val0;
    logic [WORD_W-1:0] val1;
    logic [PAIR_W-1:0] pk_data;
    logic [BE_W-1:0]   pk_be;
    res_t              nxt;
    res_t              cur;

    ldfmt_decode #(
        .RIDX_W   (RIDX_W),
        .LINK_IDX (LINK_IDX)
    ) u_decode (
        .req_valid (req_valid),
        .is_store  (is_store),
        .acc_type  (acc_type),
        .rd_idx    (rd_idx),
        .size      (size),
        .sext      (sext),
        .bad_enc   (bad_enc),
        .load_ok   (load_ok),
        .store_ok  (store_ok),
        .pair_ok   (pair_ok)
    );

    ldfmt_extract u_extract (
        .mem_data (mem_data),
        .addr_lo  (addr_lo),
        .size     (size),
        .sext     (sext),
        .val0     (val0),
        .val1     (val1)
    );

    ldfmt_store_pack u_pack (
        .store_src (store_src),
        .addr_lo   (addr_lo),
        .size      (size),
        .pk_data   (pk_data),
        .pk_be     (pk_be)
    );

    always_comb begin
        nxt        = '0;
        nxt.vld    = req_valid;
        nxt.bad    = bad_enc;
        nxt.w0_en  = load_ok;
        nxt.w1_en  = pair_ok;
        if (load_ok) begin
            nxt.w0_idx = rd_idx;
            nxt.w0_dat = val0;
        end
        if (pair_ok) begin
            nxt.w1_idx = RIDX_W'(rd_idx + 1'b1);
            nxt.w1_dat = val1;
        end
        if (store_ok) begin
            nxt.s_dat = pk_data;
            nxt.s_be  = pk_be;
        end
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cur <= '0;
            end else begin
                cur <= nxt;
            end
        end
    end else begin : g_comb
        assign cur = nxt;
    end

    assign out_valid = cur.vld;
    assign illegal   = cur.bad;
    assign wr0_en    = cur.w0_en;
    assign wr0_idx   = cur.w0_idx;
    assign wr0_data  = cur.w0_dat;
    assign wr1_en    = cur.w1_en;
    assign wr1_idx   = cur.w1_idx;
    assign wr1_data  = cur.w1_dat;
    assign st_data   = cur.s_dat;
    assign st_be     = cur.s_be;

endmodule

// File: rtl/ldfmt_chk.sv
module ldfmt_chk #(
    parameter int unsigned RIDX_W   = 4,
    parameter int unsigned LINK_IDX = 14,
    parameter bit          REG_OUT  = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              out_valid,
    input logic              illegal,
    input logic              wr0_en,
    input logic [RIDX_W-1:0] wr0_idx,
    input logic              wr1_en,
    input logic [RIDX_W-1:0] wr1_idx,
    input logic [7:0]        st_be
);

    // R6
    wr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr1_en |-> (wr0_en && (wr1_idx == RIDX_W'(wr0_idx + 1'b1))));

    // R7
    pair_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr1_en |-> (!wr0_idx[0] && (wr0_idx != RIDX_W'(LINK_IDX))));

    // R8
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!wr0_en && !wr1_en && (st_be == 8'h00)));

    // R10
    be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_be != 8'h00) |-> (!wr0_en && ($countones(st_be) == 1 ||
            $countones(st_be) == 2 || $countones(st_be) == 4 ||
            $countones(st_be) == 8)));

    // R12
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!wr0_en && !wr1_en && !illegal && (st_be == 8'h00)));

    if (REG_OUT) begin : g_lag
        // R11
        valid_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> $past(req_valid));
    end

endmodule

bind ldfmt_top ldfmt_chk #(
    .RIDX_W   (RIDX_W),
    .LINK_IDX (LINK_IDX),
    .REG_OUT  (REG_OUT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .out_valid (out_valid),
    .illegal   (illegal),
    .wr0_en    (wr0_en),
    .wr0_idx   (wr0_idx),
    .wr1_en    (wr1_en),
    .wr1_idx   (wr1_idx),
    .st_be     (st_be)
);

// File: tb/ldfmt_top_tb.sv
module ldfmt_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        is_store = 1'b0;
    logic [2:0]  acc_type = 3'd0;
    logic [1:0]  addr_lo = 2'd0;
    logic [3:0]  rd_idx = 4'd0;
    logic [63:0] mem_data = 64'd0;
    logic [63:0] store_src = 64'd0;
    logic        out_valid;
    logic        illegal;
    logic        wr0_en;
    logic [3:0]  wr0_idx;
    logic [31:0] wr0_data;
    logic        wr1_en;
    logic [3:0]  wr1_idx;
    logic [31:0] wr1_data;
    logic [63:0] st_data;
    logic [7:0]  st_be;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ldfmt_top #(.RIDX_W(4), .LINK_IDX(14), .REG_OUT(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .is_store(is_store),
        .acc_type(acc_type), .addr_lo(addr_lo), .rd_idx(rd_idx),
        .mem_data(mem_data), .store_src(store_src), .out_valid(out_valid),
        .illegal(illegal), .wr0_en(wr0_en), .wr0_idx(wr0_idx),
        .wr0_data(wr0_data), .wr1_en(wr1_en), .wr1_idx(wr1_idx),
        .wr1_data(wr1_data), .st_data(st_data), .st_be(st_be)
    );

    function automatic string tag_of(input logic st, input logic [2:0] t,
                                     input logic bad, input logic v);
        if (!v) return "R12";
        if (t > 3'd5) return "R9";
        if (st && bad) return "R8";
        if (bad) return "R7";
        if (st) return "R10";
        case (t)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic apply(input logic v, input logic st, input logic [2:0] t,
                         input logic [1:0] a, input logic [3:0] rd,
                         input logic [63:0] md, input logic [63:0] sd);
        logic        e_bad, e_ld, e_st, e_w1;
        logic [31:0] e_d0, e_d1, bsel, hsel;
        logic [63:0] e_sd;
        logic [7:0]  e_be;
        string       tag;
        @(negedge clk);
        req_valid = v; is_store = st; acc_type = t; addr_lo = a;
        rd_idx = rd; mem_data = md; store_src = sd;
        e_bad = v && ((t > 3'd5) || (st && (t == 3'd1 || t == 3'd3)) ||
                      (t == 3'd5 && (rd[0] || rd == 4'd14)));
        e_ld  = v && !st && !e_bad;
        e_st  = v && st && !e_bad;
        e_w1  = e_ld && (t == 3'd5);
        bsel  = (md[31:0] >> (8 * a)) & 32'hFF;
        hsel  = (md[31:0] >> (16 * (a / 2))) & 32'hFFFF;
        e_d0 = 0; e_d1 = 0; e_sd = 0; e_be = 0;
        if (e_ld) begin
            case (t)
                3'd0: e_d0 = bsel;
                3'd1: e_d0 = (bsel >= 128) ? bsel + 32'hFFFFFF00 : bsel;
                3'd2: e_d0 = hsel;
                3'd3: e_d0 = (hsel >= 32768) ? hsel + 32'hFFFF0000 : hsel;
                default: e_d0 = md[31:0];
            endcase
            if (e_w1) e_d1 = md[63:32];
        end
        if (e_st) begin
            case (t)
                3'd0: begin e_sd = (sd & 64'hFF) * 64'h01010101;
                            e_be = 8'd1 << a; end
                3'd2: begin e_sd = (sd & 64'hFFFF) * 64'h00010001;
                            e_be = 8'd3 << (2 * (a / 2)); end
                3'd4: begin e_sd = sd & 64'hFFFFFFFF; e_be = 8'h0F; end
                default: begin e_sd = sd; e_be = 8'hFF; end
            endcase
        end
        @(posedge clk);
        #1;
        tag = tag_of(st, t, e_bad, v);
        checks++;
        if (out_valid !== v || illegal !== e_bad || wr0_en !== e_ld ||
            wr1_en !== e_w1 || wr0_data !== e_d0 || wr1_data !== e_d1 ||
            (e_ld && wr0_idx !== rd) || (e_w1 && wr1_idx !== rd + 4'd1) ||
            st_data !== e_sd || st_be !== e_be) begin
            fails++;
            $display("FAIL %s t=%0d st=%0b a=%0d rd=%0d: got v=%0b ill=%0b en=%0b%0b idx=%0d/%0d d=%h/%h sd=%h be=%h exp v=%0b ill=%0b en=%0b%0b d=%h/%h sd=%h be=%h",
                     tag, t, st, a, rd, out_valid, illegal, wr0_en, wr1_en,
                     wr0_idx, wr1_idx, wr0_data, wr1_data, st_data, st_be,
                     v, e_bad, e_ld, e_w1, e_d0, e_d1, e_sd, e_be);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [63:0] pats [3];
        pats[0] = 64'h8899AABB_F07F80FF;
        pats[1] = 64'h01234567_7F017F01;
        pats[2] = 64'hFEDCBA98_80FF0180;

        // R11: reset holds every output low even with a request driven
        req_valid = 1'b1; acc_type = 3'd5; mem_data = pats[0];
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (out_valid || illegal || wr0_en || wr1_en || st_be != 0) begin
            fails++;
            $display("FAIL R11 reset: got v=%0b ill=%0b en=%0b%0b be=%h exp all zero",
                     out_valid, illegal, wr0_en, wr1_en, st_be);
        end
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b1;

        // R12: idle cycles
        apply(1'b0, 1'b0, 3'd5, 2'd0, 4'd2, pats[0], pats[1]);
        apply(1'b0, 1'b1, 3'd0, 2'd1, 4'd0, pats[1], pats[0]);

        // R11: one-cycle latency, result visible only after the edge
        @(negedge clk);
        req_valid = 1'b1; is_store = 1'b0; acc_type = 3'd4;
        mem_data = 64'h0000_0000_CAFE_F00D; rd_idx = 4'd3;
        #2;
        checks++;
        if (wr0_en !== 1'b0) begin
            fails++;
            $display("FAIL R11 latency: got wr0_en=%0b before edge exp 0", wr0_en);
        end

        // R1-R10 sweep
        for (int p = 0; p < 3; p++) begin
            for (int s = 0; s < 2; s++) begin
                for (int t = 0; t < 8; t++) begin
                    for (int a = 0; a < 4; a++) begin
                        for (int r = 0; r < 16; r++) begin
                            apply(1'b1, s[0], t[2:0], a[1:0], r[3:0],
                                  pats[p], pats[2 - p]);
                        end
                    end
                end
            end
        end
        apply(1'b0, 1'b0, 3'd0, 2'd0, 4'd0, pats[0], pats[0]);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule